// File: doc/BRIEF.md
# Synchronized Dual-Port Sample Demultiplexer

This block receives one sample word on every rising edge of the encode clock. It steers the words onto two output buses, port A and port B, and it reproduces the pipeline delay of a converter. An active-low sync input fixes which port a given sample lands on. The encode edge at which sync is first seen low takes the sample bound for port A. Every later sample alternates to the other port. While sync is high, nothing new reaches either port, and the data clock output holds still.

There are three operating modes.

- **Single-channel:** every sample goes to port A after four cycles. Port B stays frozen, the data clock toggles at the encode rate, and sync is ignored.
- **Interleaved:** both ports deliver five cycles after capture.
- **Dual-parallel:** port A delivers after six cycles and port B after five, so a pair of samples appears on both ports at the same edge.

In both dual-port modes the data clock runs at half the encode rate. It rises with each port B update, which lets a receiver tell the ports apart.

Top module: `sync_port_demux`

## Requirements
- R1: After synchronous reset, port_a and port_b read 0 and dclk reads 0. The sync input counts as high until it is first seen low.
- R2: In the two dual-port modes, a sample captured at an edge where sync_n is 1 never reaches either port. If no tagged word arrives, both ports and dclk keep their values.
- R3: In the dual-port modes, when sync_n is low at edge N and was high at edge N-1 (a falling edge), sample N goes to port A. Each later sample captured with sync_n low alternates B, A, B and so on. A later falling edge restarts the sequence with port A.
- R4: In interleaved mode (mode = 2'b01), a sample captured at edge N shows on its port right after edge N+5.
- R5: In dual-parallel mode (mode = 2'b10), a port A sample captured at edge N shows after edge N+6. A port B sample captured at edge N shows after edge N+5.
- R6: In single-channel mode (mode = 2'b00), a sample captured at edge N shows on port_a after edge N+4, and port_b never changes.
- R7: In single-channel mode, sync_n has no effect: every sample reaches port_a whatever its level.
- R8: In the dual-port modes, at the edge where a tagged word reaches latency 5 from capture, dclk takes 1 if that word is bound for port B and 0 if it is bound for port A. A rise of dclk therefore lines up with a port B update.
- R9: In single-channel mode, dclk inverts at every edge where port_a loads a new sample.
- R10: A port changes only at an edge where a word tagged for that port reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock; samples are captured on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Active-low data sync |
| mode | input | 2 | 00 single-channel, 01 interleaved, 10 dual-parallel (11 acts as interleaved) |
| sample_in | input | W | Sample word captured at each rising edge |
| port_a | output | W | Port A data |
| port_b | output | W | Port B data |
| dclk | output | 1 | Data clock output |

## Verification
The bench uses the default parameters: 8-bit samples and latencies of 4, 5, 6 and 5 cycles. The pipeline is therefore only six stages deep. This lets every single edge of a 200-edge run be compared in each of the three modes. The sync pattern covers several cases:

- an initial hold-off with sync high;
- long low stretches;
- a long high gap;
- a one-cycle high pulse that forces re-synchronization at an odd offset.

This exercises the restart of the A/B phase, the draining and freezing of both ports, and the data clock stalling and resuming. In single-channel mode the same sync pattern must have no effect.

// File: rtl/sync_demux_pkg.sv
package sync_demux_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_INTLV  = 2'd1,
    MODE_DUAL   = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    TAG_NONE = 2'b00,
    TAG_A    = 2'b01,
    TAG_B    = 2'b10
  } tag_e;

endpackage

// File: rtl/sdm_tagger.sv
module sdm_tagger
  import sync_demux_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sync_n,
  input  mode_e mode,
  output tag_e  tag_o
);

  logic sync_q;
  logic phase_b;
  logic fall;

  assign fall = sync_q & ~sync_n;

  always_comb begin
    if (mode == MODE_SINGLE)  tag_o = TAG_A;
    else if (sync_n)          tag_o = TAG_NONE;
    else if (fall)            tag_o = TAG_A;
    else                      tag_o = phase_b ? TAG_B : TAG_A;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 1'b1;
      phase_b <= 1'b0;
    end else begin
      sync_q <= sync_n;
      if (mode != MODE_SINGLE && !sync_n)
        phase_b <= (tag_o == TAG_A);
    end
  end

  AST_PAIR_B: assert property (@(posedge clk) disable iff (rst)
    (!sync_n && mode != MODE_SINGLE &&
     $past(!rst && !sync_n && sync_q && mode != MODE_SINGLE)) |-> tag_o == TAG_B); // R3

endmodule

// File: rtl/sdm_pipe.sv
module sdm_pipe
  import sync_demux_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [W-1:0]               sample_in,
  input  tag_e                       tag_in,
  output logic [DEPTH-1:0][W-1:0]    data_q,
  output logic [DEPTH-1:0][1:0]      tag_q
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          data_q[0] <= '0;
          tag_q[0]  <= TAG_NONE;
        end else begin
          data_q[0] <= sample_in;
          tag_q[0]  <= tag_in;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          data_q[g] <= '0;
          tag_q[g]  <= TAG_NONE;
        end else begin
          data_q[g] <= data_q[g-1];
          tag_q[g]  <= tag_q[g-1];
        end
      end
    end

    AST_TAG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(tag_q[g])); // R3
  end

endmodule

// File: rtl/sdm_outs.sv
module sdm_outs
  import sync_demux_pkg::*;
#(
  parameter int W          = 8,
  parameter int DEPTH      = 6,
  parameter int LAT_SINGLE = 4,
  parameter int LAT_INTLV  = 5,
  parameter int LAT_DUAL_A = 6,
  parameter int LAT_DUAL_B = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  mode_e                    mode,
  input  logic [DEPTH-1:0][W-1:0]  data_q,
  input  logic [DEPTH-1:0][1:0]    tag_q,
  output logic [W-1:0]             port_a,
  output logic [W-1:0]             port_b,
  output logic                     dclk
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IW-1:0] a_idx, b_idx, c_idx;
  logic          a_load, b_load;
  logic [1:0]    c_tag;

  always_comb begin
    case (mode)
      MODE_SINGLE: begin
        a_idx = IW'(LAT_SINGLE - 1);
        b_idx = IW'(LAT_SINGLE - 1);
        c_idx = IW'(LAT_SINGLE - 1);
      end
      MODE_DUAL: begin
        a_idx = IW'(LAT_DUAL_A - 1);
        b_idx = IW'(LAT_DUAL_B - 1);
        c_idx = IW'(LAT_DUAL_B - 1);
      end
      default: begin
        a_idx = IW'(LAT_INTLV - 1);
        b_idx = IW'(LAT_INTLV - 1);
        c_idx = IW'(LAT_INTLV - 1);
      end
    endcase
  end

  assign a_load = tag_q[a_idx][0];
  assign b_load = (mode != MODE_SINGLE) && tag_q[b_idx][1];
  assign c_tag  = tag_q[c_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      port_a <= '0;
      port_b <= '0;
      dclk   <= 1'b0;
    end else begin
      if (a_load) port_a <= data_q[a_idx];
      if (b_load) port_b <= data_q[b_idx];
      if (mode == MODE_SINGLE) begin
        if (a_load) dclk <= ~dclk;
      end else if (c_tag != TAG_NONE) begin
        dclk <= c_tag[1];
      end
    end
  end

  AST_SINGLE_B_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == MODE_SINGLE) |-> $stable(port_b)); // R6

  AST_DCLK_RISE_B: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) != MODE_SINGLE && $rose(dclk)) |-> $past(b_load)); // R8

  AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(a_load)) |-> $stable(port_a)); // R10

endmodule

// File: rtl/sync_port_demux.sv
module sync_port_demux
  import sync_demux_pkg::*;
#(
  parameter int W          = 8,
  parameter int LAT_SINGLE = 4,
  parameter int LAT_INTLV  = 5,
  parameter int LAT_DUAL_A = 6,
  parameter int LAT_DUAL_B = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sync_n,
  input  logic [1:0]   mode,
  input  logic [W-1:0] sample_in,
  output logic [W-1:0] port_a,
  output logic [W-1:0] port_b,
  output logic         dclk
);

  localparam int M1    = (LAT_SINGLE > LAT_INTLV) ? LAT_SINGLE : LAT_INTLV;
  localparam int M2    = (LAT_DUAL_A > LAT_DUAL_B) ? LAT_DUAL_A : LAT_DUAL_B;
  localparam int DEPTH = (M1 > M2) ? M1 : M2;

  mode_e                   mode_i;
  tag_e                    tag_new;
  logic [DEPTH-1:0][W-1:0] data_q;
  logic [DEPTH-1:0][1:0]   tag_q;

  assign mode_i = mode_e'(mode);

  sdm_tagger u_tagger (
    .clk    (clk),
    .rst    (rst),
    .sync_n (sync_n),
    .mode   (mode_i),
    .tag_o  (tag_new)
  );

  sdm_pipe #(.W(W), .DEPTH(DEPTH)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .sample_in (sample_in),
    .tag_in    (tag_new),
    .data_q    (data_q),
    .tag_q     (tag_q)
  );

  sdm_outs #(
    .W(W), .DEPTH(DEPTH), .LAT_SINGLE(LAT_SINGLE), .LAT_INTLV(LAT_INTLV),
    .LAT_DUAL_A(LAT_DUAL_A), .LAT_DUAL_B(LAT_DUAL_B)
  ) u_outs (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode_i),
    .data_q (data_q),
    .tag_q  (tag_q),
    .port_a (port_a),
    .port_b (port_b),
    .dclk   (dclk)
  );

endmodule

// File: tb/tb_sync_port_demux.sv
`timescale 1ns/1ps
module tb_sync_port_demux;

  localparam int W  = 8;
  localparam int NE = 200;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sync_n = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] sample_in = '0;
  logic [W-1:0] port_a, port_b;
  logic         dclk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sync_port_demux #(.W(W)) dut (
    .clk(clk), .rst(rst), .sync_n(sync_n), .mode(mode),
    .sample_in(sample_in), .port_a(port_a), .port_b(port_b), .dclk(dclk)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic sync_at(input int e);
    if (e < 5)   return 1'b1;
    if (e < 60)  return 1'b0;
    if (e < 75)  return 1'b1;
    if (e < 110) return 1'b0;
    if (e == 110) return 1'b1;
    if (e < 150) return 1'b0;
    if (e < 160) return 1'b1;
    return 1'b0;
  endfunction

  // tag codes used by the bench: 0 none, 1 port A, 2 port B
  int tg [NE];
  int smp[NE];

  task automatic run_mode(input int m);
    int la, lb, ea, eb, ed, prev_s, ph;
    string ra, rb, rd;
    la = (m == 0) ? 4 : (m == 2) ? 6 : 5;
    lb = 5;
    ra = (m == 0) ? "R6 R7" : (m == 1) ? "R2 R3 R4 R10" : "R2 R3 R5 R10";
    rb = (m == 0) ? "R6 R7" : (m == 1) ? "R2 R3 R4" : "R2 R3 R5";
    rd = (m == 0) ? "R9" : "R8";
    @(negedge clk);
    rst = 1'b1; mode = 2'(m); sync_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 port_a", port_a, 0);
    chk("R1 port_b", port_b, 0);
    chk("R1 dclk", dclk, 0);
    ea = 0; eb = 0; ed = 0; prev_s = 1; ph = 0;
    for (int e = 0; e < NE; e++) begin
      int s;
      s = sync_at(e);
      smp[e] = (e * 37 + m * 11 + 3) & 8'hFF;
      if (m == 0) tg[e] = 1;
      else if (s == 1) tg[e] = 0;
      else if (prev_s == 1) begin tg[e] = 1; ph = 1; end
      else begin tg[e] = ph ? 2 : 1; ph = 1 - ph; end
      prev_s = s;
      sync_n = s[0];
      sample_in = smp[e][W-1:0];
      @(posedge clk);
      if (e >= la && tg[e-la] == 1) ea = smp[e-la];
      if (m != 0 && e >= lb && tg[e-lb] == 2) eb = smp[e-lb];
      if (m == 0) begin
        if (e >= 4 && tg[e-4] == 1) ed = 1 - ed;
      end else if (e >= 5 && tg[e-5] != 0) begin
        ed = (tg[e-5] == 2) ? 1 : 0;
      end
      @(negedge clk);
      chk(ra, port_a, ea);
      chk(rb, port_b, eb);
      chk(rd, dclk, ed);
    end
  endtask

  initial begin
    run_mode(0);
    run_mode(1);
    run_mode(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule